// File: doc/BRIEF.md
# Integer-N Synthesizer Phase Comparator Core

This block is the digital heart of an integer-N frequency synthesizer loop. Two event streams arrive as one-clock-wide tick pulses in the system clock domain. The reference ticks pass through a pre-stage that either forwards every tick or only every second tick, and then through a programmable 12-bit reference divider. The feedback ticks pass through a programmable 17-bit divider. Each divider emits a single-cycle pulse once per programmed period. A two-register phase-frequency detector turns these pulses into up and down pump requests and a phase-error flag.

The pump requests are also presented gated as pump drive lines together with an explicit output-enable. When the enable is low, the external charge pump is meant to float (high impedance). A run control selects between normal operation and power save. In power save, both dividers, the pre-stage and the detector are held cleared. New divider ratios take effect only when a divider wraps, so a period already in progress is never cut short.

Top module: `pfd_synth_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, `up_req`, `dn_req`, `phase_err`, `cp_oe`, `cp_up` and `cp_dn` are all 0 after that edge.
- R2: With `ref_halve`=0 and a reference ratio N (12-bit, bit 0 is the LSB, N from 2 to 4095), the reference divider emits one pulse for every N accepted reference ticks. The pulse comes on the edge that samples the Nth tick.
- R3: With `ref_halve`=1, only every second reference tick reaches the divider (the 2nd, 4th and so on after a clear). The effective reference ratio is therefore 2N.
- R4: The feedback divider emits one pulse for every M feedback ticks, where M is the 17-bit `fb_ratio` (bit 0 is the LSB, up to 131071).
- R5: A programmed ratio of 0 or 1 behaves as 2, so every divider pulse lasts exactly one clock cycle.
- R6: A ratio input is captured when the divider leaves power save or reset, and otherwise only on the tick that completes a period. A change in the middle of a period does not alter that period.
- R7: A reference pulse sets `up_req` and a feedback pulse sets `dn_req`, each one clock edge after the divider pulse. A set request stays high until both are high. Then both clear on the next edge, unless a new pulse sets one of them again on that edge.
- R8: `phase_err` is 1 exactly when `up_req` or `dn_req` is 1.
- R9: `cp_oe` is 1 one edge after `run`=1 and `pump_on`=1, and 0 one edge after either of them is 0. `cp_up` and `cp_dn` follow `up_req` and `dn_req` only while `cp_oe`=1, and are 0 otherwise.
- R10: While `run`=0, both dividers and the pre-stage are held at their start state and ticks are ignored. `up_req`, `dn_req` and `cp_oe` are 0 one edge after `run` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | 1 = normal operation, 0 = power save |
| pump_on | input | 1 | 1 = pump drives, 0 = pump high impedance |
| ref_halve | input | 1 | 1 = halve the reference before dividing |
| ref_ratio | input | 12 | Reference divider ratio |
| fb_ratio | input | 17 | Feedback divider ratio |
| ref_tick | input | 1 | One-cycle reference event |
| fb_tick | input | 1 | One-cycle feedback event |
| up_req | output | 1 | Up pump request |
| dn_req | output | 1 | Down pump request |
| phase_err | output | 1 | Phase-error flag |
| cp_oe | output | 1 | Pump output enable (0 = high impedance) |
| cp_up | output | 1 | Gated up pump drive |
| cp_dn | output | 1 | Gated down pump drive |

## Verification
A divider pulse forms on the edge that samples the tick completing the count. The matching request shows one edge later, and `cp_oe` follows a change on `run` or `pump_on` after one edge. A model in the bench applies these delays to the same inputs the design samples at each edge and queues the expected outputs for that edge. A monitor compares them 1 ns after the edge. Inputs change only at falling edges. The directed checks wait three falling edges after the last tick, so every pending pulse has fully reached the outputs before they count phase-error events or read the request lines.

// File: rtl/pfd_synth_pkg.sv
// Package: shared constants and types for the phase comparator core.
// Assumes: ratios are unsigned binary with bit 0 as the LSB.
package pfd_synth_pkg;
    localparam int REF_W_DEF = 12;
    localparam int FB_W_DEF  = 17;
    localparam int MIN_RATIO = 2;

    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;
endpackage

// File: rtl/ref_prestage.sv
// Module: ref_prestage
// Forwards reference ticks either unchanged or one in two.
// Assumes: tick_in is a single-cycle pulse; hold clears the phase.
module ref_prestage (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic halve,
    input  logic tick_in,
    output logic tick_out
);
    logic phase_q;

    // Track which tick of a pair is current while halving.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            phase_q <= 1'b0;
        end else if (!halve) begin
            phase_q <= 1'b0;
        end else if (tick_in) begin
            phase_q <= ~phase_q;
        end
    end

    // Pass every tick, or only the second tick of each pair.
    always_comb begin
        tick_out = tick_in && (!halve || phase_q);
    end
endmodule

// File: rtl/ratio_divider.sv
// Module: ratio_divider
// Counts input ticks and emits one registered pulse per programmed period.
// Assumes: ratios below MIN_RATIO are raised to it; the ratio is captured
// on hold/reset and at the terminal tick only.
module ratio_divider #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic [W-1:0] ratio_in,
    input  logic         tick_in,
    output logic         pulse_o
);
    import pfd_synth_pkg::*;

    localparam logic [W-1:0] FLOOR = W'(MIN_RATIO);
    localparam logic [W-1:0] ONE   = W'(1);

    logic [W-1:0] ratio_q;
    logic [W-1:0] cnt_q;
    logic         pulse_q;
    logic [W-1:0] ratio_eff;
    logic         at_end;

    // Raise degenerate ratios to the floor value.
    always_comb begin
        ratio_eff = (ratio_in < FLOOR) ? FLOOR : ratio_in;
    end

    // Detect the tick that closes the current period.
    always_comb begin
        at_end = (cnt_q == (ratio_q - ONE));
    end

    // Count ticks, wrap at the end, reload ratio and fire the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt_q   <= '0;
            ratio_q <= ratio_eff;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (tick_in) begin
                if (at_end) begin
                    cnt_q   <= '0;
                    ratio_q <= ratio_eff;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + ONE;
                end
            end
        end
    end

    assign pulse_o = pulse_q;
endmodule

// File: rtl/pfd_core.sv
// Module: pfd_core
// Two-register phase-frequency detector.
// Assumes: ref_p and fb_p are single-cycle pulses; the overlap of both
// requests clears them on the next edge, while a pulse arriving on that
// edge still sets its request.
module pfd_core (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hold,
    input  logic                     ref_p,
    input  logic                     fb_p,
    output pfd_synth_pkg::pump_req_t req_o
);
    import pfd_synth_pkg::*;

    pump_req_t req_q;
    logic      both;

    // Overlap of the two requests triggers the common clear.
    always_comb begin
        both = req_q.up && req_q.dn;
    end

    // Set on divider pulses, hold until overlap, clear on overlap.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            req_q <= '0;
        end else begin
            req_q.up <= ref_p || (req_q.up && !both);
            req_q.dn <= fb_p  || (req_q.dn && !both);
        end
    end

    assign req_o = req_q;
endmodule

// File: rtl/pfd_synth_core.sv
// Module: pfd_synth_core (top)
// Reference pre-stage and divider, feedback divider, phase-frequency
// detector, and gated pump drive with an explicit output enable.
// Assumes: ticks are synchronous single-cycle pulses; run/pump_on are
// quasi-static control bits.
module pfd_synth_core #(
    parameter int REF_W = pfd_synth_pkg::REF_W_DEF,
    parameter int FB_W  = pfd_synth_pkg::FB_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pump_on,
    input  logic             ref_halve,
    input  logic [REF_W-1:0] ref_ratio,
    input  logic [FB_W-1:0]  fb_ratio,
    input  logic             ref_tick,
    input  logic             fb_tick,
    output logic             up_req,
    output logic             dn_req,
    output logic             phase_err,
    output logic             cp_oe,
    output logic             cp_up,
    output logic             cp_dn
);
    import pfd_synth_pkg::*;

    logic      hold;
    logic      ref_fwd;
    logic      ref_pulse;
    logic      fb_pulse;
    pump_req_t req;
    logic      oe_q;

    // Power save holds every stage in its start state.
    always_comb begin
        hold = !run;
    end

    ref_prestage i_prestage (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .halve    (ref_halve),
        .tick_in  (ref_tick),
        .tick_out (ref_fwd)
    );

    ratio_divider #(.W(REF_W)) i_ref_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .ratio_in (ref_ratio),
        .tick_in  (ref_fwd),
        .pulse_o  (ref_pulse)
    );

    ratio_divider #(.W(FB_W)) i_fb_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .ratio_in (fb_ratio),
        .tick_in  (fb_tick),
        .pulse_o  (fb_pulse)
    );

    pfd_core i_pfd (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .ref_p (ref_pulse),
        .fb_p  (fb_pulse),
        .req_o (req)
    );

    // Register the pump enable from the control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= 1'b0;
        end else begin
            oe_q <= run && pump_on;
        end
    end

    // Drive requests, error flag and gated pump lines.
    always_comb begin
        up_req    = req.up;
        dn_req    = req.dn;
        phase_err = req.up || req.dn;
        cp_oe     = oe_q;
        cp_up     = req.up && oe_q;
        cp_dn     = req.dn && oe_q;
    end
endmodule

// File: rtl/pfd_synth_core_chk.sv
// Module: pfd_synth_core_chk
// Temporal checks on the core, attached through bind.
module pfd_synth_core_chk (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic pump_on,
    input logic up_req,
    input logic dn_req,
    input logic phase_err,
    input logic cp_oe,
    input logic ref_pulse,
    input logic fb_pulse
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!up_req && !dn_req && !cp_oe));

    // R10
    ps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!up_req && !dn_req && !cp_oe && !ref_pulse && !fb_pulse));

    // R9
    pump_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pump_on |=> !cp_oe);

    // R5
    ref_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    // R5
    fb_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    // R7
    up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && up_req && !dn_req) |=> up_req);

    // R7
    dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && dn_req && !up_req) |=> dn_req);

    // R8
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_req || dn_req) |-> phase_err);
endmodule

bind pfd_synth_core pfd_synth_core_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .pump_on   (pump_on),
    .up_req    (up_req),
    .dn_req    (dn_req),
    .phase_err (phase_err),
    .cp_oe     (cp_oe),
    .ref_pulse (ref_pulse),
    .fb_pulse  (fb_pulse)
);

// File: tb/test_pfd_synth_core.sv
// Scoreboard bench: a model pushes expected outputs per edge, a monitor
// pops and compares them 1 ns after the edge.
module test_pfd_synth_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b1;
    logic        pump_on = 1'b1;
    logic        ref_halve = 1'b0;
    logic [11:0] ref_ratio = 12'd5;
    logic [16:0] fb_ratio = 17'd5;
    logic        ref_tick = 1'b0;
    logic        fb_tick = 1'b0;
    logic        up_req, dn_req, phase_err, cp_oe, cp_up, cp_dn;

    int checks = 0;
    int failures = 0;
    int err_rises = 0;
    bit prev_err = 1'b0;

    typedef struct {
        bit up;
        bit dn;
        bit err;
        bit oe;
        bit cu;
        bit cd;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    pfd_synth_core i_pfd_synth_core (
        .clk(clk), .rst_n(rst_n), .run(run), .pump_on(pump_on),
        .ref_halve(ref_halve), .ref_ratio(ref_ratio), .fb_ratio(fb_ratio),
        .ref_tick(ref_tick), .fb_tick(fb_tick),
        .up_req(up_req), .dn_req(dn_req), .phase_err(phase_err),
        .cp_oe(cp_oe), .cp_up(cp_up), .cp_dn(cp_dn)
    );

    function automatic int clamp2(input int r);
        return (r < 2) ? 2 : r;
    endfunction

    // Behavioural model state.
    bit m_ph = 0, m_rp = 0, m_fp = 0, m_u = 0, m_d = 0, m_oe = 0;
    int m_rc = 0, m_fc = 0, m_rr = 2, m_fr = 2;

    // Model: next outputs per edge, pushed as expected items.
    always @(posedge clk) begin
        exp_t e;
        bit nu, nd, nrp, nfp, rt;
        if (!rst_n || !run) begin
            m_ph = 0; m_rc = 0; m_fc = 0; m_rp = 0; m_fp = 0; m_u = 0; m_d = 0;
            m_rr = clamp2(int'(ref_ratio));
            m_fr = clamp2(int'(fb_ratio));
        end else begin
            nu = m_rp || (m_u && !(m_u && m_d));
            nd = m_fp || (m_d && !(m_u && m_d));
            rt = ref_tick && (!ref_halve || m_ph);
            if (!ref_halve) m_ph = 0;
            else if (ref_tick) m_ph = !m_ph;
            nrp = 0;
            if (rt) begin
                if (m_rc == m_rr - 1) begin
                    m_rc = 0; m_rr = clamp2(int'(ref_ratio)); nrp = 1;
                end else m_rc++;
            end
            nfp = 0;
            if (fb_tick) begin
                if (m_fc == m_fr - 1) begin
                    m_fc = 0; m_fr = clamp2(int'(fb_ratio)); nfp = 1;
                end else m_fc++;
            end
            m_rp = nrp; m_fp = nfp; m_u = nu; m_d = nd;
        end
        m_oe = rst_n && run && pump_on;
        e.up = m_u; e.dn = m_d; e.err = m_u || m_d;
        e.oe = m_oe; e.cu = m_u && m_oe; e.cd = m_d && m_oe;
        q.push_back(e);
    end

    task automatic cmp(input string tag, input string nm, input bit act, input bit exp);
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    // Monitor: pop the expected item for this edge and compare.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            cmp("R7", "up_req", up_req, e.up);
            cmp("R7", "dn_req", dn_req, e.dn);
            cmp("R8", "phase_err", phase_err, e.err);
            cmp("R9", "cp_oe", cp_oe, e.oe);
            cmp("R9", "cp_up", cp_up, e.cu);
            cmp("R9", "cp_dn", cp_dn, e.cd);
        end
        if (phase_err === 1'b1 && !prev_err) err_rises++;
        prev_err = (phase_err === 1'b1);
    end

    task automatic check_int(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
        end
    endtask

    task automatic ticks(input int n, input bit r, input bit f);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ref_tick = r; fb_tick = f;
        end
        @(negedge clk);
        ref_tick = 0; fb_tick = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk); run = 0;
        @(negedge clk); run = 1;
        repeat (2) @(negedge clk);
        err_rises = 0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check_int("R1", "up_req", int'(up_req), 0);
        check_int("R1", "dn_req", int'(dn_req), 0);
        check_int("R1", "phase_err", int'(phase_err), 0);
        check_int("R1", "cp_oe", int'(cp_oe), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check_int("R9", "cp_oe after reset", int'(cp_oe), 1);

        // R2 R4: lockstep ratio 5, 20 ticks -> 4 events
        ref_ratio = 5; fb_ratio = 5; restart();
        ticks(20, 1, 1);
        check_int("R2", "events ratio 5", err_rises, 4);

        // R3: halved ref ratio 5 vs fb ratio 10 -> 2 events
        ref_halve = 1; ref_ratio = 5; fb_ratio = 10; restart();
        ticks(20, 1, 1);
        check_int("R3", "events halved", err_rises, 2);
        check_int("R3", "up_req idle", int'(up_req), 0);
        ref_halve = 0;

        // R5: ratios 0 and 1 act as 2
        ref_ratio = 0; fb_ratio = 1; restart();
        ticks(20, 1, 1);
        check_int("R5", "events clamped", err_rises, 10);

        // R6: mid-period change keeps the running period
        ref_ratio = 3; fb_ratio = 3; restart();
        ticks(1, 1, 1);
        ref_ratio = 6; fb_ratio = 6;
        ticks(14, 1, 1);
        check_int("R6", "events with reload", err_rises, 3);

        // R7: reference leads, then feedback catches up
        ref_ratio = 2; fb_ratio = 4; restart();
        ticks(2, 1, 1);
        check_int("R7", "up_req lead", int'(up_req), 1);
        check_int("R7", "dn_req lead", int'(dn_req), 0);
        ticks(2, 1, 1);
        check_int("R7", "up_req cleared", int'(up_req), 0);
        check_int("R7", "events lead", err_rises, 1);

        // R4: large feedback ratio, feedback only
        ref_ratio = 4095; fb_ratio = 17'd70000; restart();
        ticks(69999, 0, 1);
        check_int("R4", "dn_req before end", int'(dn_req), 0);
        ticks(1, 0, 1);
        check_int("R4", "dn_req at end", int'(dn_req), 1);
        check_int("R8", "phase_err at end", int'(phase_err), 1);

        // R9: pump disabled keeps requests but floats pump lines
        ref_ratio = 2; fb_ratio = 2; pump_on = 0; restart();
        ticks(2, 1, 0);
        check_int("R9", "up_req pump off", int'(up_req), 1);
        check_int("R9", "cp_oe pump off", int'(cp_oe), 0);
        check_int("R9", "cp_up pump off", int'(cp_up), 0);
        pump_on = 1;
        repeat (2) @(negedge clk);
        check_int("R9", "cp_up pump on", int'(cp_up), 1);

        // R10: power save clears and ignores ticks
        ref_ratio = 4; restart();
        @(negedge clk); run = 0;
        @(negedge clk);
        check_int("R10", "cp_oe in save", int'(cp_oe), 0);
        ticks(10, 1, 0);
        check_int("R10", "up_req in save", int'(up_req), 0);
        run = 1;
        repeat (2) @(negedge clk);
        ticks(3, 1, 0);
        check_int("R10", "no early event", int'(up_req), 0);
        ticks(1, 1, 0);
        check_int("R10", "event after 4", int'(up_req), 1);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end
endmodule